// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block links two parallel buses, A and B, through two independent storage paths. One path carries A toward B and the other carries B toward A. Each path has a single storage element. A level-sensitive pass control and an edge-triggered capture with a clock enable share that element, so the path can be transparent, can hold its value, or can act as a register. Each path also has an active-low output enable that decides whether the block drives the destination bus.

The buses are modelled at the logic level with separate input, output and drive-enable signals. Per-bit drive-mask inputs tell the block which bits of each bus some outside agent drives. Any bit that nobody drives reads as the last value resolved on it, including a value the block drove itself. This is how bus hold is modelled. All state sits on one system clock. The direction clocks are sampled on that clock, and their rising edges are found by comparing each sample with the one before it.

Top module: `bus_xcvr`

## Requirements
- R1: While `ab_pass` is 1, `b_out` equals the resolved A value in the same cycle, for all 2^WIDTH values (WIDTH defaults to 18).
- R2: The A-to-B store takes the resolved A value on every clock edge while `ab_pass` is 1. When `ab_pass` drops, `b_out` shows that value. It then stays unchanged for as long as `ab_pass` is 0 and no capture occurs.
- R3: Take a `clk` edge where `ab_pass` is 0, `ab_cke_n` is 0, and `ab_clk` is 1 after being 0 at the previous `clk` edge. At that edge the store loads the resolved A value, and `b_out` shows it in the following cycle.
- R4: No capture happens while `ab_cke_n` is 1. A falling `ab_clk` never captures.
- R5: While `ab_pass` is 1, `ab_clk` and `ab_cke_n` have no effect on `b_out`.
- R6: `b_out_en` is 1 exactly when `ab_oe_n` is 0, and `a_out_en` is 1 exactly when `ba_oe_n` is 0.
- R7: The B-to-A path behaves as in R1 to R5, using `ba_pass`, `ba_clk`, `ba_cke_n`, `b_in`/`b_ext_drv` and `a_out`.
- R8: Each bus bit is resolved as follows. If its external-drive bit (`a_ext_drv`/`b_ext_drv`) is 1, the bit takes the pin input. If that drive bit is 0, the bit takes its keeper value. The keeper loads the resolved bit on every clock edge.
- R9: While the block drives a bus (`a_out_en`/`b_out_en` is 1), that bus keeper loads the driven value instead. After the drive is released with no outside driver, the bus reads that value.
- R10: After a reset (`rst_n` low at a clock edge), both stores and both keepers hold all zeros.
- R11: The environment never drives a bus bit from outside while the block's output enable for that bus is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for all storage |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | WIDTH | Value seen on the A bus pins |
| a_ext_drv | input | WIDTH | Per-bit flag: an outside agent drives this A bit |
| a_out | output | WIDTH | Value the block puts on A |
| a_out_en | output | 1 | Block drives A |
| b_in | input | WIDTH | Value seen on the B bus pins |
| b_ext_drv | input | WIDTH | Per-bit flag: an outside agent drives this B bit |
| b_out | output | WIDTH | Value the block puts on B |
| b_out_en | output | 1 | Block drives B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_pass | input | 1 | A-to-B transparent control, active high |
| ab_clk | input | 1 | A-to-B capture clock (sampled) |
| ab_cke_n | input | 1 | A-to-B capture clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_pass | input | 1 | B-to-A transparent control, active high |
| ba_clk | input | 1 | B-to-A capture clock (sampled) |
| ba_cke_n | input | 1 | B-to-A capture clock enable, active low |

## Verification
The assertions take several things for granted. The direction clocks and controls change at most once per system clock period, and each change settles before the sampling edge. They also assume that no external agent drives a bus while the block drives it. The capture checks also assume that every bit of the source bus is driven from outside. The bench changes every input only on the falling system edge, which keeps it within these assumptions. It clears the external-drive mask of a bus before it enables the block's own drive there, and it runs its capture sweeps with full drive masks.

// File: rtl/xcvr_pkg.sv
// Shared types for the bus transceiver.
// Assumes nothing beyond IEEE 1800-2017 enums.
package xcvr_pkg;

    // Operating mode of one direction's storage element in a cycle
    typedef enum logic [1:0] {
        PATH_PASS    = 2'd0,
        PATH_HOLD    = 2'd1,
        PATH_CAPTURE = 2'd2
    } path_mode_e;

endpackage

// File: rtl/xcvr_keeper.sv
// Logic-level bus-hold model for one bus.
// Resolves each bit from the pin when an outside agent drives it and
// from a per-bit keeper register otherwise. The keeper follows the
// resolved bit, or the block's own driven bit while the block drives.
// Assumes the outside agent and the block never drive together.
module xcvr_keeper #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] ext_drv,
    input  logic             own_en,
    input  logic [WIDTH-1:0] own_val,
    output logic [WIDTH-1:0] resolved
);

    localparam int MSB = WIDTH - 1;

    logic [MSB:0] keep_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Pick the pin or the kept level for this bit
        always_comb begin
            resolved[i] = ext_drv[i] ? pin_in[i] : keep_q[i];
        end

        // Remember the last level present on this bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                keep_q[i] <= 1'b0;
            end else if (own_en) begin
                keep_q[i] <= own_val[i];
            end else begin
                keep_q[i] <= resolved[i];
            end
        end
    end

endmodule

// File: rtl/xcvr_path.sv
// One transfer direction: a single storage element that is transparent
// while pass is high, captures on a sampled rising edge of the direction
// clock while pass is low and the enable is low, and holds otherwise.
// Assumes the direction clock changes at most once per system cycle.
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pass,
    input  logic             dclk,
    input  logic             dcke_n,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst_val,
    output logic             dst_en
);

    localparam int MSB = WIDTH - 1;

    logic         dclk_q;
    logic         dclk_rise;
    logic [MSB:0] store_q;
    path_mode_e   mode;

    // Track the previous sample of the direction clock (also during reset)
    always_ff @(posedge clk) begin
        dclk_q <= dclk;
    end

    assign dclk_rise = dclk & ~dclk_q;

    // Decide the storage mode; transparency outranks the clocked path
    always_comb begin
        if (pass) begin
            mode = PATH_PASS;
        end else if (dclk_rise && !dcke_n) begin
            mode = PATH_CAPTURE;
        end else begin
            mode = PATH_HOLD;
        end
    end

    // Update the storage element according to the mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            unique case (mode)
                PATH_PASS, PATH_CAPTURE: store_q <= src;
                default:                 store_q <= store_q;
            endcase
        end
    end

    // Present the source while transparent, the stored word otherwise
    always_comb begin
        dst_val = (mode == PATH_PASS) ? src : store_q;
        dst_en  = ~oe_n;
    end

endmodule

// File: rtl/bus_xcvr.sv
// Two-direction bus transceiver top. Each bus is resolved through a
// keeper, and each direction stores and forwards the resolved source
// bus toward the other side. Reads own drive only through the keeper
// register, so there is no combinational loop between the directions.
module bus_xcvr #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] a_ext_drv,
    output logic [WIDTH-1:0] a_out,
    output logic             a_out_en,
    input  logic [WIDTH-1:0] b_in,
    input  logic [WIDTH-1:0] b_ext_drv,
    output logic [WIDTH-1:0] b_out,
    output logic             b_out_en,
    input  logic             ab_oe_n,
    input  logic             ab_pass,
    input  logic             ab_clk,
    input  logic             ab_cke_n,
    input  logic             ba_oe_n,
    input  logic             ba_pass,
    input  logic             ba_clk,
    input  logic             ba_cke_n
);

    logic [WIDTH-1:0] a_res;
    logic [WIDTH-1:0] b_res;

    xcvr_keeper #(.WIDTH(WIDTH)) keep_a_i (
        .clk(clk), .rst_n(rst_n), .pin_in(a_in), .ext_drv(a_ext_drv),
        .own_en(a_out_en), .own_val(a_out), .resolved(a_res)
    );

    xcvr_keeper #(.WIDTH(WIDTH)) keep_b_i (
        .clk(clk), .rst_n(rst_n), .pin_in(b_in), .ext_drv(b_ext_drv),
        .own_en(b_out_en), .own_val(b_out), .resolved(b_res)
    );

    xcvr_path #(.WIDTH(WIDTH)) path_ab_i (
        .clk(clk), .rst_n(rst_n), .pass(ab_pass), .dclk(ab_clk),
        .dcke_n(ab_cke_n), .oe_n(ab_oe_n), .src(a_res),
        .dst_val(b_out), .dst_en(b_out_en)
    );

    xcvr_path #(.WIDTH(WIDTH)) path_ba_i (
        .clk(clk), .rst_n(rst_n), .pass(ba_pass), .dclk(ba_clk),
        .dcke_n(ba_cke_n), .oe_n(ba_oe_n), .src(b_res),
        .dst_val(a_out), .dst_en(a_out_en)
    );

endmodule

// File: rtl/bus_xcvr_chk.sv
// Property checker for bus_xcvr, bound to every instance of the top.
// Assumes controls and direction clocks are stable around clk edges.
module bus_xcvr_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_ext_drv,
    input logic [WIDTH-1:0] a_out,
    input logic             a_out_en,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_ext_drv,
    input logic [WIDTH-1:0] b_out,
    input logic             b_out_en,
    input logic             ab_oe_n,
    input logic             ab_pass,
    input logic             ab_clk,
    input logic             ab_cke_n,
    input logic             ba_oe_n,
    input logic             ba_pass,
    input logic             ba_clk,
    input logic             ba_cke_n
);

    // R1
    ab_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_pass && (&a_ext_drv)) |-> (b_out == a_in));

    // R2
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_pass && !(ab_clk && !$past(ab_clk))) |=>
        (ab_pass || (b_out == $past(b_out))));

    // R3
    ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_pass && !ab_cke_n && ab_clk && !$past(ab_clk) && (&a_ext_drv)) |=>
        (ab_pass || (b_out == $past(a_in))));

    // R4
    ab_cke_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_pass && ab_cke_n) |=> (ab_pass || $stable(b_out)));

    // R7
    ba_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_pass && (&b_ext_drv)) |-> (a_out == b_in));

    // R7
    ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_pass && !(ba_clk && !$past(ba_clk))) |=>
        (ba_pass || (a_out == $past(a_out))));

    // R7
    ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_pass && !ba_cke_n && ba_clk && !$past(ba_clk) && (&b_ext_drv)) |=>
        (ba_pass || (a_out == $past(b_in))));

    // R7
    ba_cke_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_pass && ba_cke_n) |=> (ba_pass || $stable(a_out)));

    // R11
    b_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_oe_n || b_out_en) |-> (b_ext_drv == '0));

    // R11
    a_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_oe_n || a_out_en) |-> (a_ext_drv == '0));

endmodule

bind bus_xcvr bus_xcvr_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/bus_xcvr_tb_top.sv
// Self-checking bench: sweeps every value and drive mask of a 4-bit build.
module bus_xcvr_tb_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, a_ext_drv, b_in, b_ext_drv;
    logic [W-1:0] a_out, b_out;
    logic         a_out_en, b_out_en;
    logic         ab_oe_n, ab_pass, ab_clk, ab_cke_n;
    logic         ba_oe_n, ba_pass, ba_clk, ba_cke_n;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bus_xcvr #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_ext_drv(a_ext_drv), .a_out(a_out), .a_out_en(a_out_en),
        .b_in(b_in), .b_ext_drv(b_ext_drv), .b_out(b_out), .b_out_en(b_out_en),
        .ab_oe_n(ab_oe_n), .ab_pass(ab_pass), .ab_clk(ab_clk), .ab_cke_n(ab_cke_n),
        .ba_oe_n(ba_oe_n), .ba_pass(ba_pass), .ba_clk(ba_clk), .ba_cke_n(ba_cke_n)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle_next();
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] prev;
        logic [W-1:0] expv;
        rst_n = 1'b0;
        a_in = '1; a_ext_drv = '1; b_in = '1; b_ext_drv = '0;
        ab_oe_n = 1'b1; ab_pass = 1'b0; ab_clk = 1'b0; ab_cke_n = 1'b1;
        ba_oe_n = 1'b1; ba_pass = 1'b1; ba_clk = 1'b0; ba_cke_n = 1'b1;
        repeat (3) settle_next();
        rst_n = 1'b1;
        #1;
        check("R10 store cleared", b_out, '0);
        check("R10 keeper cleared", a_out, '0);
        check("R6 B not driven", {3'b0, b_out_en}, '0);

        // Transparent sweep with the direction clock toggling (R1, R5)
        settle_next();
        b_ext_drv = '1; ab_pass = 1'b1; ab_cke_n = 1'b0;
        for (int v = 0; v < 16; v++) begin
            settle_next();
            a_in = v[W-1:0];
            ab_clk = ~ab_clk;
            #1;
            check("R1 transparent A->B", b_out, v[W-1:0]);
            check("R5 clock ignored while passing", b_out, v[W-1:0]);
        end
        settle_next();
        ab_clk = 1'b0;

        // Hold after pass falls (R2)
        for (int v = 0; v < 16; v++) begin
            settle_next();
            ab_pass = 1'b1; a_in = v[W-1:0];
            settle_next();
            ab_pass = 1'b0; a_in = ~v[W-1:0];
            #1;
            check("R2 value at pass fall", b_out, v[W-1:0]);
            repeat (3) settle_next();
            check("R2 value held", b_out, v[W-1:0]);
        end
        prev = 4'hF;

        // Edge capture, falling edge ignored (R3, R4)
        for (int v = 0; v < 16; v++) begin
            settle_next();
            a_in = v[W-1:0]; ab_clk = 1'b1;
            #1;
            check("R3 no change before edge sampled", b_out, prev);
            settle_next();
            check("R3 captured on rising edge", b_out, v[W-1:0]);
            ab_clk = 1'b0; a_in = ~v[W-1:0];
            settle_next();
            check("R4 falling edge ignored", b_out, v[W-1:0]);
            prev = v[W-1:0];
        end

        // Enable inactive blocks capture (R4)
        settle_next();
        ab_cke_n = 1'b1; a_in = 4'h3; ab_clk = 1'b1;
        settle_next();
        check("R4 disabled edge ignored", b_out, prev);
        ab_clk = 1'b0;
        settle_next();
        check("R4 disabled edge ignored later", b_out, prev);

        // Bus hold over every drive mask (R8)
        ab_pass = 1'b1;
        for (int m = 0; m < 16; m++) begin
            settle_next();
            a_ext_drv = '1; a_in = 4'hA;
            settle_next();
            a_ext_drv = m[W-1:0]; a_in = 4'h5;
            #1;
            expv = (4'h5 & m[W-1:0]) | (4'hA & ~m[W-1:0]);
            check("R8 undriven bits kept", b_out, expv);
            settle_next();
            a_in = 4'h0;
            #1;
            expv = expv & ~m[W-1:0];
            check("R8 keeper follows resolved", b_out, expv);
        end
        settle_next();
        a_ext_drv = '1;

        // Keeper holds the block's own drive (R6, R9)
        for (int k = 0; k < 4; k++) begin
            settle_next();
            a_in = 4'(3 * k + 5); b_ext_drv = '0; ab_oe_n = 1'b0;
            #1;
            check("R6 B driven", {3'b0, b_out_en}, 4'h1);
            settle_next();
            ab_oe_n = 1'b1;
            #1;
            check("R6 B released", {3'b0, b_out_en}, 4'h0);
            check("R9 B holds own drive", a_out, 4'(3 * k + 5));
            settle_next();
            check("R9 B still holds", a_out, 4'(3 * k + 5));
            b_ext_drv = '1;
        end

        // Mirror direction: transparency and capture (R7)
        for (int v = 0; v < 16; v++) begin
            settle_next();
            b_in = v[W-1:0];
            #1;
            check("R7 transparent B->A", a_out, v[W-1:0]);
        end
        settle_next();
        ba_pass = 1'b0; ba_cke_n = 1'b0; b_in = 4'h6;
        settle_next();
        check("R7 hold B->A", a_out, 4'hF);
        b_in = 4'h9; ba_clk = 1'b1;
        settle_next();
        check("R7 capture B->A", a_out, 4'h9);
        ba_cke_n = 1'b1; ba_clk = 1'b0; b_in = 4'h2;
        settle_next();
        ba_clk = 1'b1;
        settle_next();
        check("R7 disabled capture B->A", a_out, 4'h9);

        // A-side output enable (R6)
        a_ext_drv = '0; ba_oe_n = 1'b0;
        #1;
        check("R6 A driven", {3'b0, a_out_en}, 4'h1);
        settle_next();
        ba_oe_n = 1'b1;
        settle_next();
        a_ext_drv = '1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule